// File: doc/BRIEF.md
# Time-shared add/subtract filter unit

This block filters a stream of 16-bit two's complement samples through two cascaded first-order recursive sections. Both sections share a single datapath: one adder/subtractor with a fixed right shift by one bit on its second operand. Every accepted sample takes two clock cycles. The first cycle evaluates the first section and the second cycle evaluates the second section.

The first section computes `w[n] = x[n] - (w[n-1] >>> 1)`. The second section computes `y[n] = w[n] + (y[n-1] >>> 1)`.

The one-sample recursion delay of each section is held in a two-register chain that advances once per active slot. The older tap therefore always holds the result that the same section produced for the previous sample. The newer tap holds the result of the cycle just finished, and it lets the second section take `w[n]` without waiting a full sample.

A one-bit controller alternates between two states, the first-section slot and the second-section slot. This controller sets the operand source and the add/subtract mode. A sample is presented as `in_data` with `in_valid` high. The block accepts it only in the first-section slot. The filtered result appears on `out_data`, together with a one-cycle `out_valid` pulse.

Top module: `fold_biquad_addsub`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_data` is 0. Both recursion states start at zero.
- R2: For each accepted sample x, the first section produces w = x - (w_prev >>> 1). The shift is an arithmetic right shift (rounds toward minus infinity), and w_prev is the w of the previous accepted sample.
- R3: The output for each accepted sample is y = w + (y_prev >>> 1), with the same arithmetic shift. y_prev is the previous output.
- R4: Both section results wrap modulo 2^16 on overflow. For example, x = 32767 with w_prev = -32768 gives w = -16385.
- R5: A sample is accepted at a rising edge where the unit is in the first-section slot and `in_valid` is high. For that sample, `out_valid` is low in the following cycle. It is high for exactly one cycle after the next rising edge, with `out_data` equal to y.
- R6: `in_valid` or `in_data` asserted during the second-section slot (the cycle right after an acceptance) has no effect. Such a strobe is not taken as a sample, and it changes neither the current nor any later output.
- R7: While no sample is accepted, the unit stays in the first-section slot and `out_valid` stays 0. `out_data` keeps the last output value.
- R8: Samples may be offered every second cycle with no idle gap, and each produces its own output in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | 16 | Filtered output sample, two's complement, held between strobes |

## Verification
The bench goes after several corner cases, each with its own failure symptom:
- **Odd negative states.** These expose a shift that rounds toward zero or a logical shift; either would drift the recursive outputs by one or flip their sign.
- **A full-scale step against a full-scale negative state.** This forces wrap-around; a design that saturated or widened would report the clipped value.
- **Strobes during the second slot.** These carry junk data. A controller that accepted them would emit extra outputs or fold the junk into the recursion.
- **Back-to-back samples, long idle gaps and impulse responses.** These show whether the two-tap delay chain advances only on active slots. An unconditional shift would corrupt w_prev and y_prev after any gap.

// File: rtl/fold_biquad_addsub.sv
module fold_biquad_addsub #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  typedef enum logic {SLOT_A, SLOT_B} slot_t;

  slot_t               state;
  logic signed [W-1:0] tap_new, tap_old;
  logic signed [W-1:0] op_a, op_half, result;
  logic                sel_ext, do_sub, step;

  assign sel_ext = (state == SLOT_A);
  assign do_sub  = (state == SLOT_A);
  assign step    = (state == SLOT_B) || in_valid;

  assign op_a    = sel_ext ? in_data : tap_new;
  assign op_half = tap_old >>> 1;
  assign result  = do_sub ? (op_a - op_half) : (op_a + op_half);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SLOT_A;
      tap_new   <= '0;
      tap_old   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (step) begin
        tap_new <= result;
        tap_old <= tap_new;
        state   <= (state == SLOT_A) ? SLOT_B : SLOT_A;
        if (state == SLOT_B) begin
          out_valid <= 1'b1;
          out_data  <= result;
        end
      end
    end
  end

  p_slot_b_emits_r5: assert property (@(posedge clk) disable iff (rst)
    (state == SLOT_B) |=> out_valid);

  p_valid_source_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(state == SLOT_B));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_slot_b_returns_r6: assert property (@(posedge clk) disable iff (rst)
    (state == SLOT_B) |=> (state == SLOT_A));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == SLOT_A && !in_valid) |=> (state == SLOT_A && !out_valid));

  p_data_held_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/tb_fold_biquad_addsub.sv
module tb_fold_biquad_addsub;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic signed [15:0] w_m = '0;
  logic signed [15:0] y_m = '0;
  logic signed [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  fold_biquad_addsub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send(input logic signed [15:0] x, input bit junk,
                      input logic signed [15:0] jv, input int idle);
    logic signed [31:0] wi, yi;
    string tg;
    wi = 32'(x) - 32'(w_m >>> 1);
    w_m = wi[15:0];
    yi = 32'(w_m) + 32'(y_m >>> 1);
    y_m = yi[15:0];
    tg = "R2 R3";
    if (wi > 32767 || wi < -32768 || yi > 32767 || yi < -32768) tg = "R4";
    exp_q.push_back(y_m);
    tag_q.push_back(tg);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 valid low after accept", int'(out_valid), 0);
    if (junk) begin
      in_valid = 1'b1;
      in_data  = jv;
    end else begin
      in_valid = 1'b0;
    end
    @(negedge clk);
    check(out_valid == 1'b1, "R5 valid pulse", int'(out_valid), 1);
    in_valid = 1'b0;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 idle valid low", int'(out_valid), 0);
      check(out_data == y_m, "R7 idle data held", int'(out_data), int'(y_m));
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected output", int'(out_data), 0);
      end else begin
        logic signed [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, int'(out_data), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_data == 16'sd0, "R1 reset data", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 post-reset valid", int'(out_valid), 0);
    check(out_data == 16'sd0, "R1 post-reset data", int'(out_data), 0);

    send(16'sd1000, 0, 0, 1);
    for (int i = 0; i < 12; i++) send(16'sd0, 0, 0, 0);

    send(-16'sd7, 0, 0, 2);
    send(16'sd3, 0, 0, 0);
    send(-16'sd1, 0, 0, 1);

    send(-16'sd32768, 0, 0, 0);
    send(-16'sd32768, 0, 0, 0);
    send(16'sd32767, 0, 0, 1);
    send(16'sd32767, 0, 0, 0);
    send(-16'sd32768, 0, 0, 3);

    send(16'sd500, 1, 16'sd12345, 0);
    send(-16'sd300, 1, -16'sd20000, 2);
    send(16'sd77, 1, 16'sd1, 0);

    for (int i = 0; i < 60; i++) begin
      logic signed [15:0] v;
      v = 16'($urandom);
      send(v, bit'($urandom_range(0, 1)), 16'($urandom), int'($urandom_range(0, 3)));
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all outputs delivered", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule